// File: doc/BRIEF.md
# Fractional Clock-Enable Divider Chain

This block turns a 10 MHz reference clock into a strobe train whose average rate is exactly 32.768 kHz. It also produces a once-per-second tick. The ratio between the two rates is not an integer. The block reaches it with a cascade of modulo-5 counter cells. The first six cells each pass two of every five enable pulses, giving a rate of 1/2.5. The last cell passes four of every five, giving a rate of 1/1.25. The product of these ratios is (2/5)^6 × 4/5 = 256/78125, which is exactly 32768/10000000. Individual pulses are unevenly spaced, but every aligned window of 78125 reference cycles contains exactly 256 output strobes.

Every register runs on the reference clock, and no clock is gated or derived. Each cell advances only on a cycle in which its input enable is high. Each cell's output is a registered strobe that lasts one cycle and feeds the next cell. A counter of the output strobes raises the seconds tick once per 2^SEC_BITS strobes. A toggle flop driven by the output strobe gives a square-ish waveform for probing. The per-stage strobes are brought out so that each stage's rate can be observed. There is no data stream in this block, so every pin is a plain control or status pin with no valid/ready handshake.

Top module: `frac_clk_divider`

## Requirements
- R1: Each cell counts 0,1,2,3,4 and wraps to 0 on each input strobe. A 1/2.5 cell emits its strobe on the step into counts 1 and 3. After reset is released, stage 0 therefore shows the pattern 1,0,1,0,0 repeating, starting at the first clock edge. Stage 1 shows 0,1,0,0,0,0,1,0,0,0 over the same ten cycles.
- R2: Each 1/2.5 stage gives 2 output strobes per 5 input strobes. Over 78125 cycles, stages 0 to 5 give 31250, 12500, 5000, 2000, 800 and 320 strobes. No 1/2.5 stage emits its strobe in two consecutive cycles.
- R3: The final 1/1.25 stage passes an input strobe while its count is 0 to 3 and suppresses the strobe that arrives at count 4. It gives 4 output strobes per 5 input strobes, which is 256 over 78125 cycles.
- R4: `out_stb` asserts exactly 256 times in every window of 78125 consecutive cycles once the pipeline has filled. This gives 32768 strobes per 10,000,000 cycles.
- R5: `sec_tick` asserts for one cycle, in the cycle after the out strobe that completes each group of 2^SEC_BITS out strobes. With SEC_BITS=15 it does not assert within the first 160,000 cycles. With SEC_BITS=8 it asserts exactly once per 78125 cycles.
- R6: A synchronous active-high `rst` clears all counters, strobes and `dbg_sq`. Reset takes priority over a strobe that would otherwise fire in the same cycle, and the strobe sequence then restarts from the start of the R1 pattern.
- R7: `dbg_sq` toggles in the cycle after each `out_stb` and holds otherwise. Across any window that holds an even number of out strobes, its value at the end equals its value at the start.
- R8: Every strobe lasts one cycle. A stage strobe above stage 0 asserts only in the cycle after the previous stage's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| out_stb | output | 1 | One-cycle strobe averaging 32.768 kHz |
| sec_tick | output | 1 | One-cycle tick every 2^SEC_BITS out strobes |
| dbg_sq | output | 1 | Toggles on each out strobe |
| stage_stb | output | N_HALF+N_QUART | Registered strobe of each stage; bit 0 is the first stage |

## Verification
Two events can fall on the same clock edge: a synchronous reset, and a stage strobe or tick that the counters are about to emit. The bench asserts reset in the middle of a run, on a cycle where stage 0 is due to fire and `dbg_sq` may be high. It then requires every output to read zero at the next sample. After reset is released, the bench replays the ten-cycle start-up vector table and requires the same result as the first pass. This shows that reset won the edge and that the chain restarted cleanly.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic {
    DIV_2P5  = 1'b0,
    DIV_1P25 = 1'b1
  } stage_kind_e;

  localparam int unsigned CELL_MOD = 5;
  localparam int unsigned CELL_W   = $clog2(CELL_MOD);

  function automatic logic [CELL_W-1:0] cell_next(input logic [CELL_W-1:0] c);
    return (c == CELL_W'(CELL_MOD - 1)) ? '0 : c + CELL_W'(1);
  endfunction

endpackage

// File: rtl/fcd_mod5_cell.sv
module fcd_mod5_cell
  import fcd_pkg::*;
#(
  parameter stage_kind_e KIND = DIV_2P5
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic stb_o
);

  logic [CELL_W-1:0] cnt;
  logic              pass;

  generate
    if (KIND == DIV_2P5) begin : g_half
      // the next step lands on an odd count (1 or 3) from counts 0 and 2
      assign pass = ~cnt[0] & ~cnt[CELL_W-1];
    end else begin : g_quart
      // pass while the top bit is low: counts 0..3
      assign pass = ~cnt[CELL_W-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      stb_o <= 1'b0;
    end else begin
      stb_o <= en_i & pass;
      if (en_i) cnt <= cell_next(cnt);
    end
  end

endmodule

// File: rtl/fcd_sec_count.sv
module fcd_sec_count #(
  parameter int unsigned SEC_BITS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);

  logic [SEC_BITS-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= en_i & (&cnt);
      if (en_i) cnt <= cnt + SEC_BITS'(1);
    end
  end

endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider
  import fcd_pkg::*;
#(
  parameter int unsigned N_HALF   = 6,
  parameter int unsigned N_QUART  = 1,
  parameter int unsigned SEC_BITS = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic                        out_stb,
  output logic                        sec_tick,
  output logic                        dbg_sq,
  output logic [N_HALF+N_QUART-1:0]   stage_stb
);

  localparam int unsigned NSTAGE = N_HALF + N_QUART;

  logic [NSTAGE:0] chain;

  // the reference clock itself is the first stage's input: every cycle out of reset
  assign chain[0] = ~rst;

  generate
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
      localparam stage_kind_e KIND_I = (i < N_HALF) ? DIV_2P5 : DIV_1P25;
      fcd_mod5_cell #(.KIND(KIND_I)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .en_i  (chain[i]),
        .stb_o (chain[i+1])
      );
    end
  endgenerate

  assign stage_stb = chain[NSTAGE:1];
  assign out_stb   = chain[NSTAGE];

  fcd_sec_count #(.SEC_BITS(SEC_BITS)) u_sec (
    .clk    (clk),
    .rst    (rst),
    .en_i   (out_stb),
    .tick_o (sec_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) dbg_sq <= 1'b0;
    else if (out_stb) dbg_sq <= ~dbg_sq;
  end

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned N_HALF = 6,
  parameter int unsigned NSTAGE = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              out_stb,
  input logic              sec_tick,
  input logic              dbg_sq,
  input logic [NSTAGE-1:0] stage_stb
);

  // R6: everything reads zero on the cycle after a reset edge
  p_reset_clears_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stage_stb == '0 && !sec_tick && !dbg_sq));

  // R5: tick follows an out strobe by one cycle
  p_tick_after_out_r5: assert property (@(posedge clk) disable iff (rst)
    sec_tick |-> $past(out_stb));

  // R7: debug waveform flips after an out strobe and holds otherwise
  p_dbg_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(out_stb) |-> (dbg_sq != $past(dbg_sq)));
  p_dbg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(out_stb) |-> $stable(dbg_sq));

  // R8: one-cycle out strobe
  p_out_single_r8: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);

  generate
    for (genvar i = 1; i < NSTAGE; i++) begin : g_link
      // R8: a stage fires only after its upstream strobe
      p_needs_input_r8: assert property (@(posedge clk) disable iff (rst)
        stage_stb[i] |-> $past(stage_stb[i-1]));
    end
    for (genvar i = 0; i < N_HALF; i++) begin : g_gap
      // R2: a 1/2.5 stage never fires twice in a row
      p_no_double_r2: assert property (@(posedge clk) disable iff (rst)
        stage_stb[i] |=> !stage_stb[i]);
    end
  endgenerate

endmodule

bind frac_clk_divider fcd_checker #(.N_HALF(N_HALF), .NSTAGE(N_HALF + N_QUART)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_stb   (out_stb),
  .sec_tick  (sec_tick),
  .dbg_sq    (dbg_sq),
  .stage_stb (stage_stb)
);

// File: tb/tb_frac_clk_divider.sv
module tb_frac_clk_divider;

  localparam int NST   = 7;
  localparam int WIN   = 78125;
  localparam int NVEC  = 10;
  // {stage0, stage1} expected at each sample after reset release (R1)
  localparam logic [1:0] VEC [NVEC] = '{2'b10, 2'b01, 2'b10, 2'b00, 2'b00,
                                        2'b10, 2'b01, 2'b10, 2'b00, 2'b00};
  localparam int EXP_STAGE [NST] = '{31250, 12500, 5000, 2000, 800, 320, 256};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic out_stb, sec_tick, dbg_sq;
  logic [NST-1:0] stage_stb;
  logic s_out, s_tick, s_dbg;
  logic [NST-1:0] s_stage;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  frac_clk_divider dut (
    .clk(clk), .rst(rst), .out_stb(out_stb), .sec_tick(sec_tick),
    .dbg_sq(dbg_sq), .stage_stb(stage_stb)
  );

  frac_clk_divider #(.SEC_BITS(8)) dut_short (
    .clk(clk), .rst(rst), .out_stb(s_out), .sec_tick(s_tick),
    .dbg_sq(s_dbg), .stage_stb(s_stage)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic walk_vectors(input string tag);
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      check({stage_stb[0], stage_stb[1]} == VEC[k], tag,
            {stage_stb[0], stage_stb[1]}, VEC[k]);
    end
  endtask

  task automatic run_window(output int st_cnt[NST], output int o_cnt,
                            output int t_long, output int t_short, output int dbl);
    logic prev = 1'b0;
    o_cnt = 0; t_long = 0; t_short = 0; dbl = 0;
    for (int i = 0; i < NST; i++) st_cnt[i] = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      for (int i = 0; i < NST; i++) if (stage_stb[i]) st_cnt[i]++;
      if (out_stb) o_cnt++;
      if (out_stb && prev) dbl++;
      prev = out_stb;
      if (sec_tick) t_long++;
      if (s_tick) t_short++;
    end
  endtask

  initial begin
    int st[NST];
    int oc, tl, ts, db;
    logic d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: outputs clear while reset is held
    check(stage_stb == '0 && !out_stb && !sec_tick && !dbg_sq, "R6 reset state",
          {stage_stb, out_stb, sec_tick, dbg_sq}, 0);
    rst = 1'b0;
    walk_vectors("R1 start-up pattern");

    d0 = dbg_sq;
    run_window(st, oc, tl, ts, db);
    for (int i = 0; i < 6; i++)
      check(st[i] == EXP_STAGE[i], "R2 stage count", st[i], EXP_STAGE[i]);
    check(st[6] == EXP_STAGE[6], "R3 final stage count", st[6], EXP_STAGE[6]);
    check(st[6] * 5 == st[5] * 4, "R3 four of five", st[6] * 5, st[5] * 4);
    check(oc == 256, "R4 out strobes per window", oc, 256);
    check(db == 0, "R8 single-cycle out strobe", db, 0);
    check(ts == 1, "R5 short tick once", ts, 1);
    check(tl == 0, "R5 long tick absent", tl, 0);
    check(dbg_sq == d0, "R7 debug parity", dbg_sq, d0);

    run_window(st, oc, tl, ts, db);
    check(oc == 256, "R4 second window", oc, 256);
    check(ts == 1, "R5 short tick second window", ts, 1);
    check(tl == 0, "R5 long tick still absent", tl, 0);

    // R6: reset lands on an edge where stage 0 is due to fire
    while (!(stage_stb[0] == 1'b0 && stage_stb[1] == 1'b0)) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(stage_stb == '0 && !out_stb && !dbg_sq && !s_tick, "R6 reset wins edge",
          {stage_stb, out_stb, dbg_sq}, 0);
    @(negedge clk);
    check(s_dbg == 1'b0 && s_stage == '0, "R6 short instance cleared", {s_stage, s_dbg}, 0);
    rst = 1'b0;
    walk_vectors("R6 restart pattern");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule